// File: doc/BRIEF.md
# Host-to-Firmware Command Mailbox

This block is a doorbell mailbox between a host processor and a power-management microcontroller. The host sees a small 32-bit register space. It fills a source pointer, a destination pointer and up to four words of input data. It then writes one command word, and that write rings the doorbell. The firmware side receives a one-cycle request strobe together with the latched command fields and the input words. When the firmware has finished, it pulses a completion input that carries an error flag, an 8-bit error code and four words of reply data.

The command word holds the command code, the sub-command, the byte length and a flag that asks for a completion interrupt. When that flag was set, the block raises an interrupt after completion. The interrupt stays up until the host writes 1 to the pending bit of the status register. While a command is in flight, the host-writable registers are frozen, so the firmware always sees stable operands.

Control is a three-state machine:
- IDLE: waiting for a doorbell.
- ISSUE: the one cycle in which the request strobe is high.
- WAIT: waiting for completion.

Its transitions are:
- IDLE to ISSUE: a command-register write.
- ISSUE to IDLE: a completion arriving in the strobe cycle itself.
- ISSUE to WAIT: no completion in the strobe cycle.
- WAIT to IDLE: a completion.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, the status word, the command register and the interrupt output read 0, and the request strobe is low.
- R2: Host byte offsets are fixed as follows. Command is at 0x00, status at 0x04, source pointer at 0x08 and destination pointer at 0x0C. Input data word i is at 0x80+4i and reply data word i is at 0x90+4i. Source, destination and input words read back what was last written while idle.
- R3: A command-register write while idle latches the word. The request strobe is then high for exactly the next cycle. In that cycle the firmware side sees the code from bits 7:0, the sub-command from bits 15:12, the length from bits 23:16, and the current pointers and input words.
- R4: Status bit 0 (busy) reads 1 from the cycle after an accepted command write until the cycle after the completion pulse.
- R5: While busy, host writes to the command, source, destination and input-data registers have no effect, and no further request is raised.
- R6: On completion, status bit 1 takes the error flag and status bits 23:16 take the error code, whatever value it has (0 to 7 are the defined codes, anything else is unknown). Both hold until the next completion.
- R7: Completion loads all reply words from the firmware port. Host writes to reply words have no effect.
- R8: If bit 8 of the latched command was 1, the interrupt output and status bit 2 rise in the cycle after completion.
- R9: If bit 8 of the latched command was 0, completion leaves the interrupt output and status bit 2 at 0.
- R10: Writing status with bit 2 set clears the pending interrupt. Writing status with bit 2 clear, or writing any other status bit, changes nothing.
- R11: A completion pulse while idle is ignored: status, reply words and interrupt keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 8 | Host byte offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational from bus_addr |
| fw_req | output | 1 | One-cycle request strobe to firmware |
| fw_code | output | CODE_W | Latched command code |
| fw_sub | output | SUB_W | Latched sub-command |
| fw_len | output | LEN_W | Latched input length in bytes |
| fw_src | output | 32 | Source pointer |
| fw_dst | output | 32 | Destination pointer |
| fw_wbuf | output | 32*BUF_WORDS | Input data words, word 0 in the low bits |
| fw_done | input | 1 | Completion pulse from firmware |
| fw_err | input | 1 | Error flag returned with completion |
| fw_err_code | input | 8 | Error code returned with completion |
| fw_rbuf | input | 32*BUF_WORDS | Reply data words, word 0 in the low bits |
| irq | output | 1 | Completion interrupt to the host |

## Verification
The hardest corner is a completion that arrives in the very cycle the request strobe is high. This takes the ISSUE-to-IDLE path and skips WAIT. The bench reaches it by asserting the completion pulse on the same clock phase in which it sees the strobe.

Host writes made during the busy window are also hard to observe. The bench mixes them into a long wait and checks two things. First, the frozen registers read back unchanged. Second, the scoreboard queue sees no unexpected request.

A completion pulse given while idle carries distinctive reply data. This proves the reply buffer is not loaded out of turn.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } mbx_state_e;

    localparam int ADDR_W = 8;
    localparam int WORD_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STS  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_SRC  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_DST  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_WBUF = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_RBUF = 8'h90;

    localparam int STS_BUSY     = 0;
    localparam int STS_ERR      = 1;
    localparam int STS_IRQ      = 2;
    localparam int STS_CODE_LSB = 16;

    localparam int CMD_IRQ_BIT = 8;
    localparam int CMD_SUB_LSB = 12;
    localparam int CMD_LEN_LSB = 16;

endpackage

// File: rtl/mbx_wordbank.sv
module mbx_wordbank #(
    parameter int WORDS = 4,
    parameter int WIDTH = 32,
    parameter int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_we,
    input  logic [IDX_W-1:0]       host_idx,
    input  logic [WIDTH-1:0]       host_data,
    input  logic                   bulk_we,
    input  logic [WORDS*WIDTH-1:0] bulk_data,
    output logic [WORDS*WIDTH-1:0] flat
);

    // One register per word.
    // A bulk load takes priority over a single-word host write.
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [WIDTH-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (bulk_we) begin
                word_q <= bulk_data[g*WIDTH +: WIDTH];
            end else if (host_we && (host_idx == IDX_W'(g))) begin
                word_q <= host_data;
            end
        end

        assign flat[g*WIDTH +: WIDTH] = word_q;
    end

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             doorbell,
    input  logic             irq_flag,
    input  logic             fw_done,
    input  logic             fw_err,
    input  logic [ERR_W-1:0] fw_err_code,
    input  logic             irq_w1c,
    output logic             busy,
    output logic             fw_req,
    output logic             accept,
    output logic             complete,
    output logic             err_q,
    output logic [ERR_W-1:0] code_q,
    output logic             irq_pend
);

    mbx_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        complete = 1'b0;
        busy     = (state_q != ST_IDLE);
        fw_req   = (state_q == ST_ISSUE);

        unique case (state_q)
            ST_IDLE: begin
                if (doorbell) begin
                    accept  = 1'b1;
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (fw_done) begin
                    complete = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (fw_done) begin
                    complete = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Result status, captured once per completion.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            code_q <= '0;
        end else if (complete) begin
            err_q  <= fw_err;
            code_q <= fw_err_code;
        end
    end

    // Pending interrupt.
    // A new completion that asks for an interrupt wins over a same-cycle clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pend <= 1'b0;
        end else if (complete && irq_flag) begin
            irq_pend <= 1'b1;
        end else if (irq_w1c) begin
            irq_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int BUF_WORDS = 4,
    parameter int CODE_W    = 8,
    parameter int SUB_W     = 4,
    parameter int LEN_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [7:0]                  bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic                        fw_req,
    output logic [CODE_W-1:0]           fw_code,
    output logic [SUB_W-1:0]            fw_sub,
    output logic [LEN_W-1:0]            fw_len,
    output logic [31:0]                 fw_src,
    output logic [31:0]                 fw_dst,
    output logic [32*BUF_WORDS-1:0]     fw_wbuf,
    input  logic                        fw_done,
    input  logic                        fw_err,
    input  logic [7:0]                  fw_err_code,
    input  logic [32*BUF_WORDS-1:0]     fw_rbuf,
    output logic                        irq
);

    localparam int IDX_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
    localparam logic [ADDR_W-1:0] BUF_SPAN = ADDR_W'(BUF_WORDS * 4);

    // Address decode.
    logic hit_cmd, hit_sts, hit_src, hit_dst, hit_wbuf, hit_rbuf;
    logic [ADDR_W-1:0] wbuf_off, rbuf_off;
    logic [IDX_W-1:0]  wbuf_idx, rbuf_idx;

    assign wbuf_off = bus_addr - OFS_WBUF;
    assign rbuf_off = bus_addr - OFS_RBUF;
    assign wbuf_idx = wbuf_off[IDX_W+1:2];
    assign rbuf_idx = rbuf_off[IDX_W+1:2];

    assign hit_cmd  = (bus_addr == OFS_CMD);
    assign hit_sts  = (bus_addr == OFS_STS);
    assign hit_src  = (bus_addr == OFS_SRC);
    assign hit_dst  = (bus_addr == OFS_DST);
    assign hit_wbuf = (wbuf_off < BUF_SPAN);
    assign hit_rbuf = (rbuf_off < BUF_SPAN);

    logic busy, accept, complete, err_q, irq_pend;
    logic [7:0]  code_q;
    logic [31:0] cmd_q, src_q, dst_q;
    logic [32*BUF_WORDS-1:0] wbuf_flat, rbuf_flat;

    mbx_ctrl #(.ERR_W(8)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .doorbell    (bus_wr && hit_cmd),
        .irq_flag    (cmd_q[CMD_IRQ_BIT]),
        .fw_done     (fw_done),
        .fw_err      (fw_err),
        .fw_err_code (fw_err_code),
        .irq_w1c     (bus_wr && hit_sts && bus_wdata[STS_IRQ]),
        .busy        (busy),
        .fw_req      (fw_req),
        .accept      (accept),
        .complete    (complete),
        .err_q       (err_q),
        .code_q      (code_q),
        .irq_pend    (irq_pend)
    );

    // Command and pointer registers; writable only while idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            src_q <= '0;
            dst_q <= '0;
        end else begin
            if (accept) begin
                cmd_q <= bus_wdata;
            end
            if (bus_wr && !busy && hit_src) begin
                src_q <= bus_wdata;
            end
            if (bus_wr && !busy && hit_dst) begin
                dst_q <= bus_wdata;
            end
        end
    end

    mbx_wordbank #(.WORDS(BUF_WORDS), .WIDTH(32), .IDX_W(IDX_W)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (bus_wr && !busy && hit_wbuf),
        .host_idx  (wbuf_idx),
        .host_data (bus_wdata),
        .bulk_we   (1'b0),
        .bulk_data ('0),
        .flat      (wbuf_flat)
    );

    mbx_wordbank #(.WORDS(BUF_WORDS), .WIDTH(32), .IDX_W(IDX_W)) u_rbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (1'b0),
        .host_idx  ('0),
        .host_data ('0),
        .bulk_we   (complete),
        .bulk_data (fw_rbuf),
        .flat      (rbuf_flat)
    );

    // Host read mux.
    logic [31:0] sts_word;
    always_comb begin
        sts_word = '0;
        sts_word[STS_BUSY] = busy;
        sts_word[STS_ERR]  = err_q;
        sts_word[STS_IRQ]  = irq_pend;
        sts_word[STS_CODE_LSB +: 8] = code_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_cmd) begin
            bus_rdata = cmd_q;
        end else if (hit_sts) begin
            bus_rdata = sts_word;
        end else if (hit_src) begin
            bus_rdata = src_q;
        end else if (hit_dst) begin
            bus_rdata = dst_q;
        end else if (hit_wbuf) begin
            bus_rdata = wbuf_flat[32*int'(wbuf_idx) +: 32];
        end else if (hit_rbuf) begin
            bus_rdata = rbuf_flat[32*int'(rbuf_idx) +: 32];
        end
    end

    // Firmware-side view of the latched command.
    assign fw_code = cmd_q[CODE_W-1:0];
    assign fw_sub  = cmd_q[CMD_SUB_LSB +: SUB_W];
    assign fw_len  = cmd_q[CMD_LEN_LSB +: LEN_W];
    assign fw_src  = src_q;
    assign fw_dst  = dst_q;
    assign fw_wbuf = wbuf_flat;
    assign irq     = irq_pend;

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic        busy,
    input logic        fw_req,
    input logic        fw_done,
    input logic        irq,
    input logic        irq_flag,
    input logic [31:0] cmd_q
);

    logic cmd_wr;
    assign cmd_wr = bus_wr && (bus_addr == 8'h00);

    assert_doorbell_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> (fw_req && busy));

    assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fw_req |=> !fw_req);

    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fw_done) |=> busy);

    assert_cmd_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> $stable(cmd_q));

    assert_irq_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fw_done && busy));

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> irq_flag);

    assert_idle_done_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fw_done && !cmd_wr) |=> (!busy && !$rose(irq)));

endmodule

bind cmd_mailbox mbx_checker u_mbx_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .busy     (busy),
    .fw_req   (fw_req),
    .fw_done  (fw_done),
    .irq      (irq),
    .irq_flag (cmd_q[mbx_pkg::CMD_IRQ_BIT]),
    .cmd_q    (cmd_q)
);

// File: tb/test_cmd_mailbox.sv
module test_cmd_mailbox;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         fw_req;
    logic [7:0]   fw_code;
    logic [3:0]   fw_sub;
    logic [7:0]   fw_len;
    logic [31:0]  fw_src, fw_dst;
    logic [127:0] fw_wbuf;
    logic         fw_done = 1'b0;
    logic         fw_err = 1'b0;
    logic [7:0]   fw_err_code = '0;
    logic [127:0] fw_rbuf = '0;
    logic         irq;

    always #2 clk = ~clk;

    cmd_mailbox i_cmd_mailbox (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fw_req(fw_req),
        .fw_code(fw_code), .fw_sub(fw_sub), .fw_len(fw_len), .fw_src(fw_src),
        .fw_dst(fw_dst), .fw_wbuf(fw_wbuf), .fw_done(fw_done), .fw_err(fw_err),
        .fw_err_code(fw_err_code), .fw_rbuf(fw_rbuf), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct packed {
        logic [7:0]   code;
        logic [3:0]   sub;
        logic [7:0]   len;
        logic [31:0]  src;
        logic [31:0]  dst;
        logic [127:0] wbuf;
    } req_item_t;

    req_item_t exp_q[$];

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Completion pulse. wait_first=0 asserts it in the current phase.
    task automatic finish_cmd(input bit wait_first, input logic e,
                              input logic [7:0] c, input logic [127:0] rb);
        if (wait_first) @(negedge clk);
        fw_done = 1'b1; fw_err = e; fw_err_code = c; fw_rbuf = rb;
        @(negedge clk);
        fw_done = 1'b0; fw_err = 1'b0; fw_err_code = '0;
    endtask

    // Monitor: every request strobe must match the next expected item (R3, R5).
    always @(negedge clk) begin
        if (rst_n && fw_req) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R5 actual=unexpected request expected=none");
            end else begin
                req_item_t it;
                it = exp_q.pop_front();
                chk("R3 code", 128'(fw_code), 128'(it.code));
                chk("R3 sub", 128'(fw_sub), 128'(it.sub));
                chk("R3 len", 128'(fw_len), 128'(it.len));
                chk("R3 src", 128'(fw_src), 128'(it.src));
                chk("R3 dst", 128'(fw_dst), 128'(it.dst));
                chk("R3 wbuf", fw_wbuf, it.wbuf);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0]  d;
        logic [127:0] wexp;
        logic [127:0] rb_a, rb_b;
        req_item_t    it;

        rb_a = {32'hA3A3A3A3, 32'hA2A2A2A2, 32'hA1A1A1A1, 32'hA0A0A0A0};
        rb_b = {32'hB3B3B3B3, 32'hB2B2B2B2, 32'hB1B1B1B1, 32'hB0B0B0B0};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        rd(8'h04, d); chk("R1 status", 128'(d), 128'(0));
        rd(8'h00, d); chk("R1 command", 128'(d), 128'(0));
        chk("R1 irq", 128'(irq), 128'(0));
        chk("R1 req", 128'(fw_req), 128'(0));

        // R2: pointer and input-word readback.
        wr(8'h08, 32'h1111_2222);
        wr(8'h0C, 32'h3333_4444);
        wexp = '0;
        for (int i = 0; i < 4; i++) begin
            wr(8'(8'h80 + 4 * i), 32'hC0DE_0000 + 32'(i));
            wexp[32*i +: 32] = 32'hC0DE_0000 + 32'(i);
        end
        rd(8'h08, d); chk("R2 src", 128'(d), 128'(32'h1111_2222));
        rd(8'h0C, d); chk("R2 dst", 128'(d), 128'(32'h3333_4444));
        for (int i = 0; i < 4; i++) begin
            rd(8'(8'h80 + 4 * i), d);
            chk("R2 wbuf", 128'(d), 128'(32'hC0DE_0000 + 32'(i)));
        end

        // Command A: code 0x35, sub 7, len 16, interrupt requested.
        it = '{code: 8'h35, sub: 4'h7, len: 8'd16, src: 32'h1111_2222,
               dst: 32'h3333_4444, wbuf: wexp};
        exp_q.push_back(it);
        wr(8'h00, 32'h0010_7135);
        chk("R3 strobe high", 128'(fw_req), 128'(1));
        rd(8'h04, d); chk("R4 busy set", 128'(d), 128'(32'h1));
        @(negedge clk);
        chk("R3 strobe single", 128'(fw_req), 128'(0));

        // R5: writes while busy.
        wr(8'h08, 32'hDEAD_BEEF);
        wr(8'h0C, 32'hDEAD_BEEF);
        wr(8'h80, 32'hDEAD_BEEF);
        wr(8'h00, 32'h0000_0177);
        rd(8'h08, d); chk("R5 src frozen", 128'(d), 128'(32'h1111_2222));
        rd(8'h0C, d); chk("R5 dst frozen", 128'(d), 128'(32'h3333_4444));
        rd(8'h80, d); chk("R5 wbuf frozen", 128'(d), 128'(32'hC0DE_0000));
        rd(8'h00, d); chk("R5 cmd frozen", 128'(d), 128'(32'h0010_7135));
        rd(8'h04, d); chk("R4 still busy", 128'(d), 128'(32'h1));

        // Completion with error code 5.
        finish_cmd(1, 1'b1, 8'h05, rb_a);
        rd(8'h04, d); chk("R6 R8 status", 128'(d), 128'(32'h0005_0006));
        chk("R8 irq", 128'(irq), 128'(1));
        for (int i = 0; i < 4; i++) begin
            rd(8'(8'h90 + 4 * i), d);
            chk("R7 rbuf", 128'(d), 128'(rb_a[32*i +: 32]));
        end
        wr(8'h94, 32'h0);
        rd(8'h94, d); chk("R7 rbuf host write", 128'(d), 128'(32'hA1A1A1A1));

        // R10: write-1-to-clear.
        wr(8'h04, 32'h0);
        chk("R10 zero write keeps irq", 128'(irq), 128'(1));
        wr(8'h04, 32'h00FF_0003);
        rd(8'h04, d); chk("R10 other bits", 128'(d), 128'(32'h0005_0006));
        wr(8'h04, 32'h4);
        rd(8'h04, d); chk("R10 cleared", 128'(d), 128'(32'h0005_0002));
        chk("R10 irq low", 128'(irq), 128'(0));

        // R11: completion while idle.
        finish_cmd(1, 1'b0, 8'h33, rb_b);
        rd(8'h04, d); chk("R11 status", 128'(d), 128'(32'h0005_0002));
        rd(8'h90, d); chk("R11 rbuf", 128'(d), 128'(32'hA0A0A0A0));
        chk("R11 irq", 128'(irq), 128'(0));

        // Command B: no interrupt; completion in the strobe cycle.
        wr(8'h80, 32'h5555_AAAA);
        wexp[31:0] = 32'h5555_AAAA;
        it = '{code: 8'h02, sub: 4'h1, len: 8'd4, src: 32'h1111_2222,
               dst: 32'h3333_4444, wbuf: wexp};
        exp_q.push_back(it);
        wr(8'h00, 32'h0004_1002);
        chk("R3 strobe B", 128'(fw_req), 128'(1));
        finish_cmd(0, 1'b0, 8'h00, rb_b);
        rd(8'h04, d); chk("R6 R9 status B", 128'(d), 128'(32'h0));
        chk("R9 irq B", 128'(irq), 128'(0));
        rd(8'h9C, d); chk("R7 rbuf B", 128'(d), 128'(32'hB3B3B3B3));

        // Command C: unknown error code 0xC8.
        it = '{code: 8'h09, sub: 4'h0, len: 8'd0, src: 32'h1111_2222,
               dst: 32'h3333_4444, wbuf: wexp};
        exp_q.push_back(it);
        wr(8'h00, 32'h0000_0009);
        repeat (4) @(negedge clk);
        finish_cmd(0, 1'b1, 8'hC8, rb_a);
        rd(8'h04, d); chk("R6 unknown code", 128'(d), 128'(32'h00C8_0002));
        chk("R9 irq C", 128'(irq), 128'(0));

        repeat (3) @(negedge clk);
        chk("R3 queue drained", 128'(exp_q.size()), 128'(0));

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule